// File: doc/BRIEF.md
# Three-Axis Servo Register Slave

This block sits between a processor's 32-bit synchronous register bus and three identical servo axes. Each axis has three resources: a signed 10-bit drive command, a signed 8-bit position feedback value and a 3-bit error status. Each field lives alone in its own word, with its least significant bit at bit 0. Signed fields are sign-extended to the full 32 bits when read, and unsigned fields read with zero upper bits. Software can therefore load any field with a plain integer read, with no masking, shifting or shadow copies.

The address is a word address. Its upper two bits select the axis slot and its lower two bits select the word inside that slot. Each axis occupies an identical four-word block, which is 16 bytes, so axis n starts at byte address n×0x10. Inside a block, word 0 is the drive register, which can be read and written. Word 1 is the position register and word 2 is the error register, and both are read-only. Word 3 and the fourth axis slot are unmapped.

Position and error inputs are captured into registers on every clock. Any set error bit of an axis raises that axis's shutdown flag, and shutdown forces the axis's drive output to zero. The drive register itself keeps the value software last wrote. The bus has no back-pressure: every strobe is accepted in the cycle it is presented, and read data appears one clock later.

Top module: `servo_axis_regs`

## Requirements
- R1: After reset every drive register reads 0, every drive output is 0, every shutdown flag is 0 and the read data is 0.
- R2: A write to word offset 0 of axis slot 0, 1 or 2 loads that axis's drive register. A later read of the same word returns the value sign-extended from bit 9 to 32 bits.
- R3: A read of word offset 1 returns that axis's position, sign-extended from bit 7 to 32 bits, as sampled from the position input on a previous clock.
- R4: A read of word offset 2 returns that axis's 3 error bits in bits 2:0, and bits 31:3 read as zero.
- R5: An axis's shutdown flag is high exactly when any of the error-input bits that were sampled at the previous clock edge is set. Each of the three bits alone is enough.
- R6: While an axis is in shutdown its drive output is 0 and its drive register still reads back the value last written. When no shutdown is active, the drive output equals the drive register.
- R7: A write to word offset 1, 2 or 3, or to axis slot 3, changes no register and no output. A read of word offset 3 or of slot 3 returns 0.
- R8: Read data is registered. It is valid on the clock after the read strobe and holds its value until the next read strobe.
- R9: A read and a write of the same drive register in the same cycle return the value held before the write. The new value is visible to later reads.
- R10: Write-data bits 31:10 are ignored for drive writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Word address: bits 3:2 axis slot, bits 1:0 word offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pos_in | input | 24 | Position feedback, 8 bits per axis, axis 0 in the low bits |
| err_in | input | 9 | Error status, 3 bits per axis, axis 0 in the low bits |
| drive_out | output | 30 | Drive command, 10 bits per axis, axis 0 in the low bits |
| shutdown | output | 3 | Per-axis shutdown flag |

## Verification
The properties assume that no read strobe arrives in the first cycle after reset is released. They also assume that the error inputs may change at any cycle, so the shutdown check compares against the value from exactly one edge earlier. The drive-hold properties take the write strobe as the only way a drive register can change, and they excuse a change in any cycle where shutdown is active. The stimulus changes bus signals and axis inputs only on the falling clock edge. It raises strobes only after reset has been released for several cycles, and it waits two edges after changing position inputs before reading them back.

// File: rtl/servo_regs_pkg.sv
`timescale 1ns/1ps
package servo_regs_pkg;
  localparam int OFS_W = 2;

  typedef enum logic [OFS_W-1:0] {
    OFS_DRIVE = 2'd0,
    OFS_POS   = 2'd1,
    OFS_ERR   = 2'd2,
    OFS_SPARE = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/servo_addr_decode.sv
`timescale 1ns/1ps
module servo_addr_decode
  import servo_regs_pkg::*;
#(
  parameter int NUM_AXES = 3,
  parameter int IDX_W    = 2
) (
  input  logic [IDX_W+OFS_W-1:0] addr,
  input  logic                   wr,
  output logic [NUM_AXES-1:0]    drv_wr,
  output logic [IDX_W-1:0]       axis_idx,
  output reg_ofs_e               ofs,
  output logic                   mapped
);
  assign axis_idx = addr[IDX_W+OFS_W-1:OFS_W];
  assign ofs      = reg_ofs_e'(addr[OFS_W-1:0]);
  assign mapped   = (int'({1'b0, axis_idx}) < NUM_AXES);

  // one write enable per axis, only for the drive word of a mapped slot
  for (genvar a = 0; a < NUM_AXES; a++) begin : g_wr
    assign drv_wr[a] = wr && mapped && (ofs == OFS_DRIVE) && (axis_idx == IDX_W'(a));
  end
endmodule

// File: rtl/servo_axis_channel.sv
`timescale 1ns/1ps
module servo_axis_channel #(
  parameter int DRV_W = 10,
  parameter int POS_W = 8,
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DRV_W-1:0] wdata,
  input  logic [POS_W-1:0] pos_raw,
  input  logic [ERR_W-1:0] err_raw,
  output logic [DRV_W-1:0] drive_q,
  output logic [POS_W-1:0] pos_q,
  output logic [ERR_W-1:0] err_q,
  output logic [DRV_W-1:0] drive_gated,
  output logic             stop
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q <= '0;
      pos_q   <= '0;
      err_q   <= '0;
    end else begin
      pos_q <= pos_raw;
      err_q <= err_raw;
      if (wr_en) drive_q <= wdata;
    end
  end

  assign stop        = |err_q;
  assign drive_gated = stop ? '0 : drive_q;
endmodule

// File: rtl/servo_read_port.sv
`timescale 1ns/1ps
module servo_read_port
  import servo_regs_pkg::*;
#(
  parameter int NUM_AXES = 3,
  parameter int DRV_W    = 10,
  parameter int POS_W    = 8,
  parameter int ERR_W    = 3,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd,
  input  logic [IDX_W-1:0]                  axis_idx,
  input  reg_ofs_e                          ofs,
  input  logic                              mapped,
  input  logic [NUM_AXES-1:0][DRV_W-1:0]    drv,
  input  logic [NUM_AXES-1:0][POS_W-1:0]    pos,
  input  logic [NUM_AXES-1:0][ERR_W-1:0]    err,
  output logic [DATA_W-1:0]                 rdata
);
  logic [DRV_W-1:0]  sel_drv;
  logic [POS_W-1:0]  sel_pos;
  logic [ERR_W-1:0]  sel_err;
  logic [DATA_W-1:0] word;

  always_comb begin
    sel_drv = '0;
    sel_pos = '0;
    sel_err = '0;
    for (int a = 0; a < NUM_AXES; a++) begin
      if (axis_idx == IDX_W'(a)) begin
        sel_drv = drv[a];
        sel_pos = pos[a];
        sel_err = err[a];
      end
    end
  end

  always_comb begin
    word = '0;
    if (mapped) begin
      case (ofs)
        OFS_DRIVE: word = {{(DATA_W-DRV_W){sel_drv[DRV_W-1]}}, sel_drv};
        OFS_POS:   word = {{(DATA_W-POS_W){sel_pos[POS_W-1]}}, sel_pos};
        OFS_ERR:   word = {{(DATA_W-ERR_W){1'b0}}, sel_err};
        default:   word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= word;
  end
endmodule

// File: rtl/servo_axis_regs.sv
`timescale 1ns/1ps
module servo_axis_regs
  import servo_regs_pkg::*;
#(
  parameter int  NUM_AXES = 3,
  parameter int  DRV_W    = 10,
  parameter int  POS_W    = 8,
  parameter int  ERR_W    = 3,
  parameter int  DATA_W   = 32,
  localparam int IDX_W    = (NUM_AXES > 1) ? $clog2(NUM_AXES) : 1,
  localparam int ADDR_W   = IDX_W + OFS_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_AXES*POS_W-1:0] pos_in,
  input  logic [NUM_AXES*ERR_W-1:0] err_in,
  output logic [NUM_AXES*DRV_W-1:0] drive_out,
  output logic [NUM_AXES-1:0]       shutdown
);
  logic [NUM_AXES-1:0]             drv_wr;
  logic [IDX_W-1:0]                axis_idx;
  reg_ofs_e                        ofs;
  logic                            mapped;
  logic [NUM_AXES-1:0][POS_W-1:0]  pos_vec;
  logic [NUM_AXES-1:0][ERR_W-1:0]  err_vec;
  logic [NUM_AXES-1:0][DRV_W-1:0]  drv_q;
  logic [NUM_AXES-1:0][POS_W-1:0]  pos_q;
  logic [NUM_AXES-1:0][ERR_W-1:0]  err_q;
  logic [NUM_AXES-1:0][DRV_W-1:0]  drv_gated;
  logic                            unused_wdata_hi;

  assign pos_vec         = pos_in;
  assign err_vec         = err_in;
  assign drive_out       = drv_gated;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:DRV_W];

  servo_addr_decode #(.NUM_AXES(NUM_AXES), .IDX_W(IDX_W)) u_dec (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .drv_wr   (drv_wr),
    .axis_idx (axis_idx),
    .ofs      (ofs),
    .mapped   (mapped)
  );

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    servo_axis_channel #(.DRV_W(DRV_W), .POS_W(POS_W), .ERR_W(ERR_W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (drv_wr[a]),
      .wdata       (bus_wdata[DRV_W-1:0]),
      .pos_raw     (pos_vec[a]),
      .err_raw     (err_vec[a]),
      .drive_q     (drv_q[a]),
      .pos_q       (pos_q[a]),
      .err_q       (err_q[a]),
      .drive_gated (drv_gated[a]),
      .stop        (shutdown[a])
    );
  end

  servo_read_port #(
    .NUM_AXES(NUM_AXES), .DRV_W(DRV_W), .POS_W(POS_W), .ERR_W(ERR_W),
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (bus_rd),
    .axis_idx (axis_idx),
    .ofs      (ofs),
    .mapped   (mapped),
    .drv      (drv_q),
    .pos      (pos_q),
    .err      (err_q),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/servo_axis_regs_chk.sv
`timescale 1ns/1ps
module servo_axis_regs_chk #(
  parameter int NUM_AXES = 3,
  parameter int DRV_W    = 10,
  parameter int ERR_W    = 3,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [NUM_AXES*ERR_W-1:0] err_in,
  input logic [NUM_AXES*DRV_W-1:0] drive_out,
  input logic [NUM_AXES-1:0]       shutdown
);
  logic rd_drive, rd_err, rd_void, wr_void;
  assign rd_drive = (bus_addr[1:0] == 2'd0) && (int'({1'b0, bus_addr[ADDR_W-1:2]}) < NUM_AXES);
  assign rd_err   = (bus_addr[1:0] == 2'd2) && (int'({1'b0, bus_addr[ADDR_W-1:2]}) < NUM_AXES);
  assign rd_void  = (bus_addr[1:0] == 2'd3) || (int'({1'b0, bus_addr[ADDR_W-1:2]}) >= NUM_AXES);
  assign wr_void  = (bus_addr[1:0] != 2'd0) || (int'({1'b0, bus_addr[ADDR_W-1:2]}) >= NUM_AXES);

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_rd)) |-> $stable(bus_rdata));

  p_drive_sext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_rd) && $past(rd_drive)) |->
      (bus_rdata[DATA_W-1:DRV_W-1] == {(DATA_W-DRV_W+1){bus_rdata[DRV_W-1]}}));

  p_err_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_rd) && $past(rd_err)) |-> (bus_rdata[DATA_W-1:ERR_W] == '0));

  p_void_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_rd) && $past(rd_void)) |-> (bus_rdata == '0));

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_ax
    p_shutdown_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (shutdown[a] == (|$past(err_in[a*ERR_W +: ERR_W]))));

    p_gate_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown[a] |-> (drive_out[a*DRV_W +: DRV_W] == '0));

    p_drive_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !shutdown[a]) |=> (shutdown[a] || $stable(drive_out[a*DRV_W +: DRV_W])));

    p_void_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && wr_void && !shutdown[a]) |=> (shutdown[a] || $stable(drive_out[a*DRV_W +: DRV_W])));
  end
endmodule

bind servo_axis_regs servo_axis_regs_chk #(
  .NUM_AXES(NUM_AXES), .DRV_W(DRV_W), .ERR_W(ERR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/servo_axis_regs_test.sv
`timescale 1ns/1ps
module servo_axis_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [23:0] pos_in = '0;
  logic [8:0]  err_in = '0;
  logic [29:0] drive_out;
  logic [2:0]  shutdown;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  servo_axis_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pos_in(pos_in), .err_in(err_in),
    .drive_out(drive_out), .shutdown(shutdown)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] wa(input int axis, input int ofs);
    return {2'(axis), 2'(ofs)};
  endfunction

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: scoreboard pop one clock after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        #1;
        if (exp_q.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R8: read with no expected item, actual %h expected none", bus_rdata);
        end else begin
          check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check({2'b0, drive_out}, 32'h0, "R1 drive_out");
    check({29'b0, shutdown}, 32'h0, "R1 shutdown");
    check(bus_rdata, 32'h0, "R1 rdata");
    for (int a = 0; a < 3; a++) rd_exp(wa(a, 0), 32'h0, "R1 drive reg");

    // R2 drive writes and sign extension
    wr_reg(wa(0, 0), 32'h0000_01FF);
    wr_reg(wa(1, 0), 32'h0000_0200);
    wr_reg(wa(2, 0), 32'h0000_03FD);
    rd_exp(wa(0, 0), 32'h0000_01FF, "R2 axis0 +511");
    rd_exp(wa(1, 0), 32'hFFFF_FE00, "R2 axis1 -512");
    rd_exp(wa(2, 0), 32'hFFFF_FFFD, "R2 axis2 -3");
    // R10 upper write bits ignored
    wr_reg(wa(0, 0), 32'hABCD_E07F);
    rd_exp(wa(0, 0), 32'h0000_007F, "R10 upper bits ignored");
    @(negedge clk);
    check({22'b0, drive_out[9:0]}, 32'h7F, "R6 axis0 drive_out");
    check({22'b0, drive_out[19:10]}, 32'h200, "R6 axis1 drive_out");

    // R3 position readback
    pos_in = {8'hC3, 8'h7F, 8'h80};
    repeat (2) @(negedge clk);
    rd_exp(wa(0, 1), 32'hFFFF_FF80, "R3 axis0 -128");
    rd_exp(wa(1, 1), 32'h0000_007F, "R3 axis1 +127");
    rd_exp(wa(2, 1), 32'hFFFF_FFC3, "R3 axis2 neg");

    // R5 / R6 shutdown timing and gating
    @(negedge clk);
    err_in = 9'b000_101_000;
    #1 check({29'b0, shutdown}, 32'h0, "R5 before edge");
    @(posedge clk); #1;
    check({29'b0, shutdown}, 32'h2, "R5 one edge later");
    check({22'b0, drive_out[19:10]}, 32'h0, "R6 gated to zero");
    check({22'b0, drive_out[9:0]}, 32'h7F, "R6 other axis untouched");
    rd_exp(wa(1, 2), 32'h0000_0005, "R4 error bits");
    rd_exp(wa(1, 0), 32'hFFFF_FE00, "R6 reg keeps value");
    @(negedge clk);
    err_in = '0;
    @(posedge clk); #1;
    check({29'b0, shutdown}, 32'h0, "R5 cleared");
    check({22'b0, drive_out[19:10]}, 32'h200, "R6 restored");
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      err_in = 9'(1 << (6 + b));
      @(posedge clk); #1;
      check({29'b0, shutdown}, 32'h4, "R5 single bit");
      check({22'b0, drive_out[29:20]}, 32'h0, "R6 single bit gate");
      rd_exp(wa(2, 2), 32'(1 << b), "R4 single bit");
    end
    @(negedge clk);
    err_in = '0;
    repeat (2) @(negedge clk);

    // R7 ignored writes and void reads
    wr_reg(wa(0, 1), 32'h0000_0011);
    wr_reg(wa(0, 2), 32'h0000_0022);
    wr_reg(wa(0, 3), 32'h0000_0033);
    wr_reg(wa(3, 0), 32'h0000_0044);
    wr_reg(wa(3, 2), 32'h0000_0055);
    @(negedge clk);
    check({2'b0, drive_out}, {2'b0, 10'h3FD, 10'h200, 10'h07F}, "R7 outputs unchanged");
    rd_exp(wa(0, 0), 32'h0000_007F, "R7 axis0 drive unchanged");
    rd_exp(wa(1, 0), 32'hFFFF_FE00, "R7 axis1 drive unchanged");
    rd_exp(wa(2, 0), 32'hFFFF_FFFD, "R7 axis2 drive unchanged");
    rd_exp(wa(0, 1), 32'hFFFF_FF80, "R7 position unchanged");
    rd_exp(wa(0, 2), 32'h0, "R7 error unchanged");
    rd_exp(wa(1, 3), 32'h0, "R7 spare word reads zero");
    rd_exp(wa(3, 0), 32'h0, "R7 slot3 reads zero");
    rd_exp(wa(3, 1), 32'h0, "R7 slot3 pos reads zero");

    // R8 read data held without a strobe
    rd_exp(wa(2, 1), 32'hFFFF_FFC3, "R8 read");
    wr_reg(wa(1, 0), 32'h0000_0155);
    pos_in = 24'h123456;
    repeat (3) @(negedge clk);
    check(bus_rdata, 32'hFFFF_FFC3, "R8 held");

    // R9 simultaneous read and write
    @(negedge clk);
    bus_addr = wa(2, 0); bus_wdata = 32'h0000_0005; bus_wr = 1'b1; bus_rd = 1'b1;
    exp_q.push_back(32'hFFFF_FFFD); tag_q.push_back("R9 old value");
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    rd_exp(wa(2, 0), 32'h0000_0005, "R9 new value");
    rd_exp(wa(1, 0), 32'h0000_0155, "R2 rewrite axis1");
    rd_exp(wa(0, 1), 32'h0000_0056, "R3 new position");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R8: actual %0d pending reads expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule